// File: doc/BRIEF.md
# Programmable IR pulse-timing decoder

This block receives consumer infrared remote-control frames that encode each bit as a mark followed by a space. The raw IR input is synchronised into the system clock. The input polarity is selectable. The input is sampled on each pulse of a slow IR tick enable. For every symbol the decoder measures the mark width and the whole mark-plus-space period. It tests both values against programmable min/max windows: one window set for the leader and four window sets for data symbols. Accepted data bits go into a 64-bit shift register. An idle gap at least as long as the programmed free time closes the frame.

A word-addressed register bus configures the decoder and reads back its results. Software programs the windows, the free time and the length bounds, then enables the decoder. It reads the captured length and the 64-bit data when data-valid is set. An optional 64-bit masked compare replaces the plain data-valid interrupt with a match interrupt. A third interrupt source reports raw input transitions.

The frame state machine has five states. `ST_OFF` is the decoder halted. `ST_DROP` waits for a free-time idle gap before listening. `ST_IDLE` waits for the first mark. `ST_MARK` counts a mark. `ST_SPACE` counts a space. The transitions are:
- OFF to DROP on the first tick after enable.
- DROP to IDLE once the gap is seen.
- IDLE to MARK on a mark.
- MARK to SPACE when the mark ends.
- SPACE to MARK when the next mark starts and the symbol is accepted.
- SPACE to DROP when the next mark starts and the symbol fits no window.
- SPACE to IDLE when the gap ends the frame.
- Any state to OFF when the enable bit is cleared.

Top module: `irpt_decoder`

Register map (word addresses):
- 0: control. Bit 0 is enable, bit 1 is polarity (1 means the mark is low), bit 2 is MSB-first, bit 3 is bit inversion, bit 4 is leader required.
- 1: leader window.
- 2 to 5: data windows 00, 01, 10, 11.
- Window word layout: [7:0] width min, [15:8] width max, [23:16] period min, [31:24] period max.
- 6: frame word. [7:0] free time, [12:8] min length, [21:16] max length.
- 7: status. Bit 0 is data-valid, [14:8] is the received length.
- 8 and 9: data, low word and high word.
- 10 and 11: filter data, low word and high word.
- 12 and 13: filter mask, low word and high word.
- 14: interrupt enable.
- 15: interrupt status.
- 16: interrupt clear.
- Interrupt bits, in all three interrupt registers: bit 0 is valid, bit 1 is match, bit 2 is edge.

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A data symbol is accepted when its mark width W (in ticks) lies in [wmin, wmax] and its period P satisfies P/2 in [pmin, pmax]. The windows are tried in the order 00, 01, 10, 11 and the first hit wins. A hit on window 00 or 10 gives bit 0; a hit on window 01 or 11 gives bit 1.
- R3: With leader required set, the first symbol of a frame must satisfy W/16 and P/16 within the leader window, or the frame is discarded. With leader required clear, the first symbol is a data symbol.
- R4: A symbol that fits no window aborts the frame without setting data-valid. The decoder then waits for an idle gap of the free time before it accepts a new frame.
- R5: A frame ends when the input stays idle for 8 × free-time ticks after a mark. An accepted frame sets status bit 0 and writes its bit count to status[14:8].
- R6: A frame whose bit count is below the min length or above the max length is discarded silently. Both bounds are inclusive.
- R7: With control bit 2 clear, bit i of the frame lands in data bit i. With it set, the first bit lands in bit n−1. Control bit 3 inverts every bit.
- R8: With control bit 1 set, a low input level is a mark.
- R9: Writing 0 to status bit 0 clears data-valid. Writing 1 to it leaves data-valid unchanged.
- R10: With an all-zero filter mask, a completed frame raises valid status (bit 0). With a non-zero mask, the frame raises match status (bit 1) only when the masked data equals the masked filter data, and valid status is not raised.
- R11: Every change of the synchronised input seen on a tick raises edge status (bit 2).
- R12: Writing a 1 to a bit of the interrupt clear register clears that status bit. `irq` is high exactly when some status bit and its enable bit are both set.
- R13: The min length is stored with bit 0 forced to zero (5 bits, at most 30). The max length is stored with bit 0 forced to zero and capped at 48.
- R14: While control bit 0 is clear the decoder captures no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_tick | input | 1 | One-cycle IR sample enable |
| ir_in | input | 1 | Raw asynchronous IR input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
A sweep sends leader frames of every even length between the two bounds. It runs under all four combinations of bit orientation and inversion, with pseudo-random payloads, so a misplaced bit, a reversed order or a missed inversion shows up in the data words. Frames one bit below and one bit above the bounds separate inclusive limits from exclusive ones. Symbols aimed at the third and fourth windows, a symbol that fits no window, and a frame without a leader each test a different branch of the accept logic. Matching and non-matching filter values, an inverted-polarity run and a disabled run separate the interrupt and control paths.

// File: rtl/irpt_pkg.sv
package irpt_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_MARK  = 3'd2,
        ST_SPACE = 3'd3,
        ST_DROP  = 3'd4
    } fsm_state_t;

    typedef struct packed {
        logic [7:0] pmax;
        logic [7:0] pmin;
        logic [7:0] wmax;
        logic [7:0] wmin;
    } sym_win_t;

    typedef struct packed {
        logic lead_en;
        logic inv;
        logic msb_first;
        logic pol;
        logic en;
    } ctrl_t;

    localparam int BUS_W     = 32;
    localparam int NUM_DSYM  = 4;
    localparam int SHR_W     = 64;
    localparam int LEN_W     = 7;
    localparam int NUM_IRQ   = 3;
    localparam int IRQ_VALID = 0;
    localparam int IRQ_MATCH = 1;
    localparam int IRQ_EDGE  = 2;
    localparam int MAXLEN_CAP = 48;

    localparam int REG_CTRL  = 0;
    localparam int REG_LEAD  = 1;
    localparam int REG_SYM0  = 2;
    localparam int REG_FRAME = 6;
    localparam int REG_STAT  = 7;
    localparam int REG_DLO   = 8;
    localparam int REG_DHI   = 9;
    localparam int REG_FDLO  = 10;
    localparam int REG_FDHI  = 11;
    localparam int REG_FMLO  = 12;
    localparam int REG_FMHI  = 13;
    localparam int REG_IEN   = 14;
    localparam int REG_ISTAT = 15;
    localparam int REG_ICLR  = 16;

endpackage

// File: rtl/irpt_win.sv
module irpt_win
    import irpt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int W_SH  = 0,
    parameter int P_SH  = 1
) (
    input  logic [CNT_W-1:0] w_cnt,
    input  logic [CNT_W-1:0] p_cnt,
    input  sym_win_t         win,
    output logic             hit
);
    logic [CNT_W-1:0] w_s;
    logic [CNT_W-1:0] p_s;

    always_comb begin
        w_s = w_cnt >> W_SH;
        p_s = p_cnt >> P_SH;
        hit = (w_s >= CNT_W'(win.wmin)) && (w_s <= CNT_W'(win.wmax)) &&
              (p_s >= CNT_W'(win.pmin)) && (p_s <= CNT_W'(win.pmax));
    end
endmodule

// File: rtl/irpt_fsm.sv
module irpt_fsm
    import irpt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                sig,
    input  ctrl_t               ctrl,
    input  logic [7:0]          ft_min,
    input  logic [4:0]          min_len,
    input  logic [5:0]          max_len,
    input  logic                lead_hit,
    input  logic [NUM_DSYM-1:0] data_hit,
    output logic [CNT_W-1:0]    w_cnt,
    output logic [CNT_W-1:0]    p_cnt,
    output logic                done,
    output logic [LEN_W-1:0]    done_len,
    output logic [SHR_W-1:0]    done_data,
    output fsm_state_t          state
);
    localparam logic [LEN_W-1:0] LEN_SAT = '1;

    fsm_state_t       nxt;
    logic [CNT_W-1:0] sp_cnt;
    logic [CNT_W-1:0] sp_nxt;
    logic [CNT_W-1:0] ft_thr;
    logic [LEN_W-1:0] bits;
    logic [SHR_W-1:0] shreg;
    logic             lead_ok;
    logic             gap_done;
    logic             want_lead;
    logic             sym_ok;
    logic             bit_raw;
    logic             bit_val;
    logic             len_ok;
    logic             accept;

    function automatic logic [CNT_W-1:0] sinc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    always_comb begin
        ft_thr    = CNT_W'({ft_min, 3'b000});
        sp_nxt    = sinc(sp_cnt);
        gap_done  = sp_nxt >= ft_thr;
        want_lead = ctrl.lead_en && !lead_ok;
        sym_ok    = want_lead ? lead_hit : (|data_hit);
        if (data_hit[0])      bit_raw = 1'b0;
        else if (data_hit[1]) bit_raw = 1'b1;
        else if (data_hit[2]) bit_raw = 1'b0;
        else                  bit_raw = 1'b1;
        bit_val   = bit_raw ^ ctrl.inv;
        len_ok    = (bits >= LEN_W'(min_len)) && (bits <= LEN_W'(max_len));
        accept    = gap_done && len_ok && (!ctrl.lead_en || lead_ok);
    end

    // next-state decode
    always_comb begin
        nxt = state;
        if (!ctrl.en) begin
            nxt = ST_OFF;
        end else if (tick) begin
            unique case (state)
                ST_OFF:   nxt = ST_DROP;
                ST_DROP:  if (!sig && gap_done) nxt = ST_IDLE;
                ST_IDLE:  if (sig) nxt = ST_MARK;
                ST_MARK:  if (!sig) nxt = ST_SPACE;
                ST_SPACE: begin
                    if (sig)           nxt = sym_ok ? ST_MARK : ST_DROP;
                    else if (gap_done) nxt = ST_IDLE;
                end
                default:  nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // counters, shift register and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_cnt     <= '0;
            p_cnt     <= '0;
            sp_cnt    <= '0;
            bits      <= '0;
            shreg     <= '0;
            lead_ok   <= 1'b0;
            done      <= 1'b0;
            done_len  <= '0;
            done_data <= '0;
        end else begin
            done <= 1'b0;
            if (!ctrl.en) begin
                w_cnt   <= '0;
                p_cnt   <= '0;
                sp_cnt  <= '0;
                bits    <= '0;
                shreg   <= '0;
                lead_ok <= 1'b0;
            end else if (tick) begin
                unique case (state)
                    ST_OFF: sp_cnt <= '0;
                    ST_DROP: sp_cnt <= sig ? '0 : sp_nxt;
                    ST_IDLE: begin
                        if (sig) begin
                            w_cnt   <= CNT_W'(1);
                            p_cnt   <= CNT_W'(1);
                            bits    <= '0;
                            shreg   <= '0;
                            lead_ok <= 1'b0;
                        end
                    end
                    ST_MARK: begin
                        p_cnt <= sinc(p_cnt);
                        if (sig) begin
                            w_cnt <= sinc(w_cnt);
                        end else begin
                            sp_cnt <= CNT_W'(1);
                        end
                    end
                    ST_SPACE: begin
                        if (sig) begin
                            if (sym_ok) begin
                                if (want_lead) begin
                                    lead_ok <= 1'b1;
                                end else begin
                                    if (bits < LEN_W'(SHR_W)) begin
                                        if (ctrl.msb_first)
                                            shreg <= {shreg[SHR_W-2:0], bit_val};
                                        else
                                            shreg[bits[LEN_W-2:0]] <= bit_val;
                                    end
                                    if (bits != LEN_SAT) bits <= bits + 1'b1;
                                end
                                w_cnt <= CNT_W'(1);
                                p_cnt <= CNT_W'(1);
                            end else begin
                                sp_cnt <= '0;
                            end
                        end else begin
                            p_cnt  <= sinc(p_cnt);
                            sp_cnt <= sp_nxt;
                            if (accept) begin
                                done      <= 1'b1;
                                done_len  <= bits;
                                done_data <= shreg;
                            end
                        end
                    end
                    default: sp_cnt <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irpt_regs.sv
module irpt_regs
    import irpt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                done,
    input  logic [LEN_W-1:0]    done_len,
    input  logic [SHR_W-1:0]    done_data,
    input  logic                edge_evt,
    output ctrl_t               ctrl,
    output sym_win_t            lead_win,
    output sym_win_t [NUM_DSYM-1:0] data_win,
    output logic [7:0]          ft_min,
    output logic [4:0]          min_len,
    output logic [5:0]          max_len,
    output logic                stat_valid,
    output logic [LEN_W-1:0]    rx_len,
    output logic [NUM_IRQ-1:0]  irq_stat,
    output logic                irq
);
    logic [SHR_W-1:0]   rx_data;
    logic [SHR_W-1:0]   flt_data;
    logic [SHR_W-1:0]   flt_mask;
    logic [NUM_IRQ-1:0] irq_en;
    logic [NUM_IRQ-1:0] irq_set;
    logic [NUM_IRQ-1:0] irq_clr;
    logic [5:0]         max_wr;
    logic               mask_on;
    logic               masked_eq;

    function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int r);
        return a == ADDR_W'(r);
    endfunction

    always_comb begin
        mask_on   = |flt_mask;
        masked_eq = ((done_data ^ flt_data) & flt_mask) == '0;
        irq_set            = '0;
        irq_set[IRQ_VALID] = done && !mask_on;
        irq_set[IRQ_MATCH] = done && mask_on && masked_eq;
        irq_set[IRQ_EDGE]  = edge_evt;
        irq_clr = (bus_wr && hit_addr(bus_addr, REG_ICLR)) ? bus_wdata[NUM_IRQ-1:0] : '0;
        max_wr  = {bus_wdata[21:17], 1'b0};
        if (max_wr > 6'(MAXLEN_CAP)) max_wr = 6'(MAXLEN_CAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl       <= '0;
            lead_win   <= '0;
            data_win   <= '0;
            ft_min     <= '0;
            min_len    <= '0;
            max_len    <= '0;
            stat_valid <= 1'b0;
            rx_len     <= '0;
            rx_data    <= '0;
            flt_data   <= '0;
            flt_mask   <= '0;
            irq_en     <= '0;
            irq_stat   <= '0;
        end else begin
            if (bus_wr) begin
                if (hit_addr(bus_addr, REG_CTRL))  ctrl <= ctrl_t'(bus_wdata[4:0]);
                if (hit_addr(bus_addr, REG_LEAD))  lead_win <= sym_win_t'(bus_wdata);
                for (int k = 0; k < NUM_DSYM; k++)
                    if (hit_addr(bus_addr, REG_SYM0 + k)) data_win[k] <= sym_win_t'(bus_wdata);
                if (hit_addr(bus_addr, REG_FRAME)) begin
                    ft_min  <= bus_wdata[7:0];
                    min_len <= {bus_wdata[12:9], 1'b0};
                    max_len <= max_wr;
                end
                if (hit_addr(bus_addr, REG_FDLO)) flt_data[31:0]  <= bus_wdata;
                if (hit_addr(bus_addr, REG_FDHI)) flt_data[63:32] <= bus_wdata;
                if (hit_addr(bus_addr, REG_FMLO)) flt_mask[31:0]  <= bus_wdata;
                if (hit_addr(bus_addr, REG_FMHI)) flt_mask[63:32] <= bus_wdata;
                if (hit_addr(bus_addr, REG_IEN))  irq_en <= bus_wdata[NUM_IRQ-1:0];
            end
            if (done) begin
                stat_valid <= 1'b1;
                rx_len     <= done_len;
                rx_data    <= done_data;
            end else if (bus_wr && hit_addr(bus_addr, REG_STAT) && !bus_wdata[0]) begin
                stat_valid <= 1'b0;
            end
            irq_stat <= (irq_stat & ~irq_clr) | irq_set;
        end
    end

    assign irq = |(irq_stat & irq_en);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(REG_CTRL):  bus_rdata = {27'd0, ctrl};
            ADDR_W'(REG_LEAD):  bus_rdata = lead_win;
            ADDR_W'(REG_FRAME): bus_rdata = {10'd0, max_len, 3'd0, min_len, ft_min};
            ADDR_W'(REG_STAT):  bus_rdata = {17'd0, rx_len, 7'd0, stat_valid};
            ADDR_W'(REG_DLO):   bus_rdata = rx_data[31:0];
            ADDR_W'(REG_DHI):   bus_rdata = rx_data[63:32];
            ADDR_W'(REG_FDLO):  bus_rdata = flt_data[31:0];
            ADDR_W'(REG_FDHI):  bus_rdata = flt_data[63:32];
            ADDR_W'(REG_FMLO):  bus_rdata = flt_mask[31:0];
            ADDR_W'(REG_FMHI):  bus_rdata = flt_mask[63:32];
            ADDR_W'(REG_IEN):   bus_rdata = {29'd0, irq_en};
            ADDR_W'(REG_ISTAT): bus_rdata = {29'd0, irq_stat};
            default:            bus_rdata = '0;
        endcase
        for (int k = 0; k < NUM_DSYM; k++)
            if (hit_addr(bus_addr, REG_SYM0 + k)) bus_rdata = data_win[k];
    end
endmodule

// File: rtl/irpt_decoder.sv
module irpt_decoder
    import irpt_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_tick,
    input  logic              ir_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic [SYNC_STAGES-1:0]  sync_q;
    logic                    lvl;
    logic                    lvl_prev;
    logic                    sig;
    logic                    edge_evt;
    ctrl_t                   ctrl;
    sym_win_t                lead_win;
    sym_win_t [NUM_DSYM-1:0] data_win;
    logic [7:0]              ft_min;
    logic [4:0]              min_len;
    logic [5:0]              max_len;
    logic                    stat_valid;
    logic [LEN_W-1:0]        rx_len;
    logic [NUM_IRQ-1:0]      irq_stat;
    logic [CNT_W-1:0]        w_cnt;
    logic [CNT_W-1:0]        p_cnt;
    logic                    lead_hit;
    logic [NUM_DSYM-1:0]     data_hit;
    logic                    frame_done;
    logic [LEN_W-1:0]        done_len;
    logic [SHR_W-1:0]        done_data;
    fsm_state_t              fsm_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '0;
            lvl_prev <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ir_in};
            if (ir_tick) lvl_prev <= lvl;
        end
    end

    assign lvl      = sync_q[SYNC_STAGES-1];
    assign sig      = lvl ^ ctrl.pol;
    assign edge_evt = ir_tick && (lvl != lvl_prev);

    irpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(frame_done), .done_len(done_len), .done_data(done_data), .edge_evt(edge_evt),
        .ctrl(ctrl), .lead_win(lead_win), .data_win(data_win),
        .ft_min(ft_min), .min_len(min_len), .max_len(max_len),
        .stat_valid(stat_valid), .rx_len(rx_len), .irq_stat(irq_stat), .irq(irq)
    );

    irpt_win #(.CNT_W(CNT_W), .W_SH(4), .P_SH(4)) u_lead_win (
        .w_cnt(w_cnt), .p_cnt(p_cnt), .win(lead_win), .hit(lead_hit)
    );

    for (genvar gi = 0; gi < NUM_DSYM; gi++) begin : g_dwin
        irpt_win #(.CNT_W(CNT_W), .W_SH(0), .P_SH(1)) u_win (
            .w_cnt(w_cnt), .p_cnt(p_cnt), .win(data_win[gi]), .hit(data_hit[gi])
        );
    end

    irpt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(ir_tick), .sig(sig), .ctrl(ctrl),
        .ft_min(ft_min), .min_len(min_len), .max_len(max_len),
        .lead_hit(lead_hit), .data_hit(data_hit),
        .w_cnt(w_cnt), .p_cnt(p_cnt),
        .done(frame_done), .done_len(done_len), .done_data(done_data),
        .state(fsm_state)
    );
endmodule

// File: rtl/irpt_chk.sv
module irpt_chk
    import irpt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               stat_valid,
    input logic [LEN_W-1:0]   rx_len,
    input logic [4:0]         min_len,
    input logic [5:0]         max_len,
    input logic [NUM_IRQ-1:0] irq_stat,
    input logic [4:0]         ctrl_bits,
    input logic               frame_done,
    input fsm_state_t         fsm_state
);
    logic wr_stat0;
    logic wr_clr_valid;
    assign wr_stat0     = bus_wr && (bus_addr == ADDR_W'(REG_STAT)) && !bus_wdata[0];
    assign wr_clr_valid = bus_wr && (bus_addr == ADDR_W'(REG_ICLR)) && bus_wdata[IRQ_VALID];

    // R6: a newly reported frame lies within the length bounds
    a_r6_len_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_valid) |-> (rx_len >= LEN_W'(min_len)) && (rx_len <= LEN_W'(max_len)));

    // R14: no frame completes after a cycle with the decoder disabled
    a_r14_halt_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_bits[0] |=> !frame_done);

    // R4: an aborted frame never reports
    a_r4_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DROP) |-> !frame_done);

    // R10: valid and match status are never raised together
    a_r10_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(irq_stat[IRQ_VALID]) && $rose(irq_stat[IRQ_MATCH])));

    // R12: valid status only falls after a clear write
    a_r12_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_stat[IRQ_VALID]) |-> $past(wr_clr_valid));

    // R9: data-valid holds unless written back to zero
    a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !wr_stat0) |=> stat_valid);
endmodule

bind irpt_decoder irpt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stat_valid(stat_valid), .rx_len(rx_len), .min_len(min_len), .max_len(max_len),
    .irq_stat(irq_stat), .ctrl_bits(ctrl), .frame_done(frame_done), .fsm_state(fsm_state)
);

// File: tb/sim_irpt_decoder.sv
module sim_irpt_decoder;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ir_tick = 1'b0;
    logic          ir_in = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  pol_b = 1'b0;
    int  tdiv = 0;

    irpt_decoder #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ir_tick(ir_tick), .ir_in(ir_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            tdiv = tdiv + 1;
            ir_tick = (tdiv % 4 == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_tick;
        do @(posedge clk); while (ir_tick !== 1'b1);
    endtask

    task automatic align;
        wait_tick();
        @(negedge clk);
    endtask

    task automatic hold(input logic lvl, input int n);
        ir_in = lvl ^ pol_b;
        repeat (n) wait_tick();
        @(negedge clk);
    endtask

    task automatic sym(input int mk, input int sp);
        hold(1'b1, mk);
        hold(1'b0, sp);
    endtask

    task automatic send_frame(input logic [63:0] pat, input int n, input bit lead);
        align();
        if (lead) sym(64, 32);
        for (int i = 0; i < n; i++) sym(4, pat[i] ? 12 : 4);
        sym(4, 60);
    endtask

    function automatic logic [63:0] exp_data(input logic [63:0] pat, input int n, input bit msb, input bit inv);
        logic [63:0] v = '0;
        for (int i = 0; i < n; i++) begin
            if (msb) v = {v[62:0], pat[i] ^ inv};
            else     v[i] = pat[i] ^ inv;
        end
        return v;
    endfunction

    task automatic clr_all;
        wr(7, 32'd0);
        wr(16, 32'd7);
    endtask

    task automatic chk_frame(input string req, input logic [63:0] exp, input int n);
        logic [31:0] st, lo, hi;
        rd(7, st); rd(8, lo); rd(9, hi);
        chk(st == ((32'(n) << 8) | 32'd1), {req, " status"}, 64'(st), 64'((n << 8) | 1));
        chk({hi, lo} == exp, {req, " data"}, {hi, lo}, exp);
    endtask

    task automatic chk_none(input string req);
        logic [31:0] st;
        rd(7, st);
        chk(st[0] == 1'b0, req, 64'(st[0]), 64'd0);
    endtask

    initial begin
        #(20 * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] pat;
        logic [63:0] ex;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a <= 16; a++) begin
            rd(a, d);
            chk(d == 32'd0, "R1 reset reg", 64'(d), 64'd0);
        end
        chk(irq == 1'b0, "R1 irq", 64'(irq), 64'd0);

        // R13: length field normalisation
        wr(6, 32'h003F_1F06);
        rd(6, d);
        chk(d == ((32'd48 << 16) | (32'd30 << 8) | 32'd6), "R13 caps", 64'(d), 64'h0030_1E06);
        wr(6, 32'h0007_0506);
        rd(6, d);
        chk(d == ((32'd6 << 16) | (32'd4 << 8) | 32'd6), "R13 even", 64'(d), 64'h0006_0406);

        // configuration: windows {pmax,pmin,wmax,wmin}
        wr(1, {8'd7, 8'd5, 8'd5, 8'd3});
        wr(2, {8'd5, 8'd3, 8'd5, 8'd3});
        wr(3, {8'd9, 8'd7, 8'd5, 8'd3});
        wr(4, {8'd17, 8'd15, 8'd5, 8'd3});
        wr(5, {8'd13, 8'd11, 8'd5, 8'd3});
        wr(6, (32'd16 << 16) | (32'd4 << 8) | 32'd6);
        wr(14, 32'd1);
        wr(0, 32'h11);
        align(); hold(1'b0, 60);

        // R2 R5 R7 R10: sweep lengths and orientation/inversion
        for (int m = 0; m < 4; m++) begin
            wr(0, 32'h11 | (32'(m & 1) << 2) | (32'(m >> 1) << 3));
            for (int n = 4; n <= 16; n += 2) begin
                pat = 64'hA5C3_96E1_0F5A_3CC3 ^ (64'(n + 16 * m) * 64'h9E37_79B9_7F4A_7C15);
                clr_all();
                send_frame(pat, n, 1'b1);
                ex = exp_data(pat, n, m[0], m[1]);
                chk_frame("R5 R7", ex, n);
                chk(irq == 1'b1, "R10 valid irq", 64'(irq), 64'd1);
            end
        end
        wr(0, 32'h11);

        // R12: clearing the interrupt drops irq
        wr(16, 32'd1);
        @(negedge clk);
        chk(irq == 1'b0, "R12 clear", 64'(irq), 64'd0);

        // R6: lengths outside the bounds
        clr_all();
        send_frame(64'h5, 3, 1'b1);
        chk_none("R6 below min");
        send_frame(64'h1_2345, 17, 1'b1);
        chk_none("R6 above max");

        // R3: leader required but absent, then leader not required
        send_frame(64'hB6, 8, 1'b0);
        chk_none("R3 no leader");
        wr(0, 32'h01);
        send_frame(64'hB6, 8, 1'b0);
        chk_frame("R3 leader off", 64'hB6, 8);
        wr(0, 32'h11);

        // R4: symbol fitting no window, then recovery
        clr_all();
        align();
        sym(64, 32); sym(4, 4); sym(4, 12); sym(4, 8); sym(4, 4); sym(4, 12); sym(4, 60);
        chk_none("R4 abort");
        send_frame(64'h0D, 6, 1'b1);
        chk_frame("R4 recover", 64'h0D, 6);

        // R2: alternate windows 10 (bit 0) and 11 (bit 1)
        clr_all();
        align();
        sym(64, 32); sym(4, 4); sym(4, 28); sym(4, 20); sym(4, 12); sym(4, 60);
        chk_frame("R2 alt windows", 64'hC, 4);

        // R9: write 1 keeps valid, write 0 clears
        wr(7, 32'd1);
        rd(7, d);
        chk(d[0] == 1'b1, "R9 write one", 64'(d[0]), 64'd1);
        wr(7, 32'd0);
        rd(7, d);
        chk(d[0] == 1'b0, "R9 write zero", 64'(d[0]), 64'd0);

        // R10: masked match and mismatch
        wr(14, 32'd3);
        wr(12, 32'h0000_00FF);
        wr(10, 32'h0000_005A);
        clr_all();
        send_frame(64'h5A, 8, 1'b1);
        rd(15, d);
        chk((d & 32'd3) == 32'd2, "R10 match", 64'(d & 3), 64'd2);
        chk(irq == 1'b1, "R10 match irq", 64'(irq), 64'd1);
        wr(16, 32'd2);
        rd(15, d);
        chk(d[1] == 1'b0, "R12 clear match", 64'(d[1]), 64'd0);
        clr_all();
        send_frame(64'h5B, 8, 1'b1);
        rd(15, d);
        chk((d & 32'd3) == 32'd0, "R10 mismatch", 64'(d & 3), 64'd0);
        chk_frame("R10 mismatch data", 64'h5B, 8);
        wr(12, 32'd0);

        // R11: edge interrupt
        wr(14, 32'd4);
        clr_all();
        @(negedge clk);
        chk(irq == 1'b0, "R11 quiet", 64'(irq), 64'd0);
        align(); hold(1'b1, 4); hold(1'b0, 60);
        rd(15, d);
        chk(d[2] == 1'b1 && irq == 1'b1, "R11 edge", 64'(d[2]), 64'd1);
        wr(16, 32'd4);
        @(negedge clk);
        chk(irq == 1'b0, "R12 clear edge", 64'(irq), 64'd0);
        wr(14, 32'd1);

        // R8: inverted polarity
        wr(0, 32'h00);
        pol_b = 1'b1;
        align(); hold(1'b0, 4);
        wr(0, 32'h13);
        align(); hold(1'b0, 60);
        clr_all();
        send_frame(64'h96, 8, 1'b1);
        chk_frame("R8 polarity", 64'h96, 8);

        // R14: decoder disabled
        wr(0, 32'h00);
        pol_b = 1'b0;
        align(); hold(1'b0, 4);
        clr_all();
        send_frame(64'h33, 8, 1'b1);
        chk_none("R14 disabled");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule